// File: doc/BRIEF.md
# Pipelined AHB-Lite Burst Master

This block is the bus-side engine of an AHB-Lite master. A client on the command side gives it a start address, a burst kind, a transfer size, a direction and, for open-ended incrementing bursts, a beat count. The block then issues one address phase per beat and overlaps each beat's data phase with the next beat's address phase. When the slave holds HREADY low, the whole pipeline stands still.

Write data comes from a small per-beat source port. A beat whose data is not yet available is held back: before the first beat the bus stays IDLE, and inside a burst the block inserts BUSY cycles. Read data is handed back one beat at a time. When a burst finishes, the block raises a one-cycle completion pulse. If an ERROR response arrives, the remaining beats are cancelled, and the same pulse carries an error flag and the index of the beat that failed.

Wrapping bursts keep every address inside an aligned block whose size is the beat count times the bytes per beat. Incrementing bursts step linearly through memory.

Top module: `ahbl_burst_master`

## Requirements
- R1: After a synchronous reset, HTRANS is IDLE (00), `cmd_ready` is high, and `done` and `rd_valid` are low.
- R2: HTRANS uses IDLE=00, BUSY=01, NONSEQ=10 and SEQ=11. The first beat of a burst goes out as NONSEQ and each later beat as SEQ. Once the last beat has been accepted, HTRANS returns to IDLE.
- R3: The beat count follows HBURST: 000 SINGLE gives 1 beat, 001 INCR gives `cmd_len`+1 beats, 011 INCR4 gives 4, 101 INCR8 gives 8 and 111 INCR16 gives 16. In incrementing bursts, HADDR rises by 2^HSIZE bytes from one beat to the next.
- R4: The wrapping kinds are 010 WRAP4, 100 WRAP8 and 110 WRAP16. Their beats step by 2^HSIZE bytes but stay inside the block of (beats × 2^HSIZE) bytes aligned to that size, wrapping from the top of the block back to its base.
- R5: While HREADY is low and no error response is in progress, HADDR and HTRANS keep their values.
- R6: The write data of beat k is the k-th word taken from the source (`wr_take` high). It is driven on HWDATA during that beat's data phase.
- R7: For each read beat whose data phase completes with an OKAY response, `rd_valid` pulses one cycle later, and `rd_data` holds the HRDATA value of that data phase.
- R8: A write beat is issued only in a cycle where `wr_avail` is high. If a later beat of a write burst is waiting for data, HTRANS is BUSY. Read bursts never use BUSY and ignore `wr_avail`.
- R9: In the first cycle of an ERROR response (HRESP high, HREADY low), the next cycle drives HTRANS to IDLE, and no further beat of that burst is accepted. `done` then pulses with `done_err` high and `err_beat` equal to the index of the failing beat, counting from 0.
- R10: During the NONSEQ beat, HBURST, HSIZE and HWRITE carry the command's values. `done` pulses one cycle after the last data phase completes, and `cmd_ready` is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block is idle and can take a command |
| cmd_addr | input | AW | Start byte address |
| cmd_burst | input | 3 | Burst kind (HBURST encoding) |
| cmd_size | input | 3 | Transfer size, log2 of bytes per beat |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_len | input | LENW | Beats minus one for an INCR burst |
| wr_avail | input | 1 | Write source has a word ready |
| wr_data | input | DW | Word offered by the write source |
| wr_take | output | 1 | Source word is consumed at this edge |
| rd_valid | output | 1 | One read word is returned |
| rd_data | output | DW | Returned read word |
| done | output | 1 | Burst finished (pulse) |
| done_err | output | 1 | Finished burst ended on an error |
| err_beat | output | LENW | Index of the failing beat |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst kind on the bus |
| hsize | output | 3 | Transfer size on the bus |
| hwrite | output | 1 | Bus direction |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Slave ready |
| hresp | input | 1 | Slave error response |

## Verification
A corrupted beat counter shows up at the ports as soon as the beat after the fault is accepted. The beat then carries the wrong NONSEQ/SEQ kind or the wrong address, or the burst runs one address phase too long or too short, and `done` comes early or late. A broken wrap mask or stride shows up on the first beat that should wrap or step. A bad data-phase record shows up one cycle after the affected data phase: the wrong word on HWDATA, a `rd_valid` pulse that is missing or extra, or an error index that is off by one. A lost cancel after an ERROR shows up in the very next cycle as an HTRANS value other than IDLE.

// File: rtl/ahbl_pkg.sv
package ahbl_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } htrans_t;

    localparam logic [2:0] BU_SINGLE = 3'b000;
    localparam logic [2:0] BU_INCR   = 3'b001;

    // Wrapping kinds keep the block aligned to beats x bytes.
    function automatic logic is_wrap(input logic [2:0] b);
        return (b == 3'b010) || (b == 3'b100) || (b == 3'b110);
    endfunction

    function automatic logic [4:0] fixed_beats(input logic [2:0] b);
        case (b)
            3'b010, 3'b011: return 5'd4;
            3'b100, 3'b101: return 5'd8;
            3'b110, 3'b111: return 5'd16;
            default:        return 5'd1;
        endcase
    endfunction

    function automatic logic [2:0] wrap_lg(input logic [2:0] b);
        case (b)
            3'b010:  return 3'd2;
            3'b100:  return 3'd3;
            3'b110:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/ahbl_addr_step.sv
module ahbl_addr_step
    import ahbl_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    size,
    input  logic [2:0]    burst,
    output logic [AW-1:0] nxt,
    output logic [AW-1:0] blk_mask
);
    localparam int SHW = 4;

    logic [AW-1:0]  stride;
    logic [AW-1:0]  lin;
    logic [SHW-1:0] blk_lg;

    always_comb begin
        stride = AW'(1) << size;
        lin    = cur + stride;
        blk_lg = {1'b0, size} + {1'b0, wrap_lg(burst)};
        if (is_wrap(burst)) begin
            blk_mask = (AW'(1) << blk_lg) - AW'(1);
            nxt      = (cur & ~blk_mask) | (lin & blk_mask);
        end else begin
            blk_mask = '0;
            nxt      = lin;
        end
    end
endmodule

// File: rtl/ahbl_addr_phase.sv
module ahbl_addr_phase
    import ahbl_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int LENW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hready,
    input  logic            kill,
    input  logic            start,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [2:0]      cmd_burst,
    input  logic [2:0]      cmd_size,
    input  logic            cmd_write,
    input  logic [LENW-1:0] cmd_len,
    input  logic            wr_avail,
    input  logic [DW-1:0]   wr_data,
    output logic [AW-1:0]   haddr,
    output htrans_t         htrans,
    output logic [2:0]      hburst,
    output logic [2:0]      hsize,
    output logic            hwrite,
    output logic            run,
    output logic            wr_take,
    output logic [LENW-1:0] ap_beat,
    output logic            ap_last,
    output logic [DW-1:0]   ap_data
);
    logic [AW-1:0]   nxt_addr;
    logic [AW-1:0]   base_addr;
    logic [AW-1:0]   step_nxt;
    logic [AW-1:0]   blk_mask;
    logic [2:0]      c_burst;
    logic [2:0]      c_size;
    logic            c_write;
    logic [LENW-1:0] iss_idx;
    logic [LENW-1:0] total_m1;
    logic            first_beat;
    logic            last_beat;
    logic            can_step;

    ahbl_addr_step #(.AW(AW)) u_step (
        .cur      (nxt_addr),
        .size     (c_size),
        .burst    (c_burst),
        .nxt      (step_nxt),
        .blk_mask (blk_mask)
    );

    assign first_beat = (iss_idx == '0);
    assign last_beat  = (iss_idx == total_m1);
    assign can_step   = run && hready && !kill;
    assign wr_take    = can_step && c_write && wr_avail;

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            htrans    <= TR_IDLE;
            haddr     <= '0;
            hburst    <= BU_SINGLE;
            hsize     <= '0;
            hwrite    <= 1'b0;
            nxt_addr  <= '0;
            base_addr <= '0;
            c_burst   <= BU_SINGLE;
            c_size    <= '0;
            c_write   <= 1'b0;
            iss_idx   <= '0;
            total_m1  <= '0;
            ap_beat   <= '0;
            ap_last   <= 1'b0;
            ap_data   <= '0;
        end else begin
            if (kill) begin
                htrans <= TR_IDLE;
                run    <= 1'b0;
            end else if (hready) begin
                if (!run) begin
                    htrans <= TR_IDLE;
                end else if (c_write && !wr_avail) begin
                    htrans <= first_beat ? TR_IDLE : TR_BUSY;
                    haddr  <= nxt_addr;
                end else begin
                    htrans   <= first_beat ? TR_NSEQ : TR_SEQ;
                    haddr    <= nxt_addr;
                    hburst   <= c_burst;
                    hsize    <= c_size;
                    hwrite   <= c_write;
                    ap_data  <= wr_data;
                    ap_beat  <= iss_idx;
                    ap_last  <= last_beat;
                    iss_idx  <= iss_idx + LENW'(1);
                    nxt_addr <= step_nxt;
                    if (last_beat) run <= 1'b0;
                end
            end
            if (start) begin
                run       <= 1'b1;
                iss_idx   <= '0;
                nxt_addr  <= cmd_addr;
                base_addr <= cmd_addr;
                c_burst   <= cmd_burst;
                c_size    <= cmd_size;
                c_write   <= cmd_write;
                total_m1  <= (cmd_burst == BU_INCR) ? cmd_len
                                                    : LENW'(fixed_beats(cmd_burst) - 5'd1);
            end
        end
    end

    AST_PIPE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!hready && !kill) |=> ($stable(haddr) && $stable(htrans))); // R5
    AST_BUSY_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (htrans == TR_BUSY) |-> hwrite); // R8
    AST_NSEQ_ONCE: assert property (@(posedge clk) disable iff (rst)
        (htrans == TR_NSEQ && hready && !kill) |=> (htrans != TR_NSEQ)); // R2
    AST_WRAP_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (htrans == TR_SEQ && is_wrap(hburst)) |-> (((haddr ^ base_addr) & ~blk_mask) == '0)); // R4
endmodule

// File: rtl/ahbl_data_phase.sv
module ahbl_data_phase #(
    parameter int DW   = 32,
    parameter int LENW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hready,
    input  logic            hresp,
    input  logic [DW-1:0]   hrdata,
    input  logic            ap_live,
    input  logic            ap_write,
    input  logic [LENW-1:0] ap_beat,
    input  logic            ap_last,
    input  logic [DW-1:0]   ap_data,
    output logic [DW-1:0]   hwdata,
    output logic            dp_valid,
    output logic            kill,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            done,
    output logic            done_err,
    output logic [LENW-1:0] err_beat
);
    typedef struct packed {
        logic            wr;
        logic            last;
        logic [LENW-1:0] beat;
    } dp_tag_t;

    dp_tag_t tag;

    assign kill = dp_valid && hresp;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_valid <= 1'b0;
            tag      <= '0;
            hwdata   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
            done_err <= 1'b0;
            err_beat <= '0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            if (hready) begin
                if (dp_valid) begin
                    if (hresp) begin
                        done     <= 1'b1;
                        done_err <= 1'b1;
                        err_beat <= tag.beat;
                    end else begin
                        if (!tag.wr) begin
                            rd_valid <= 1'b1;
                            rd_data  <= hrdata;
                        end
                        if (tag.last) begin
                            done     <= 1'b1;
                            done_err <= 1'b0;
                        end
                    end
                end
                if (ap_live && !kill) begin
                    dp_valid <= 1'b1;
                    tag      <= '{wr: ap_write, last: ap_last, beat: ap_beat};
                    hwdata   <= ap_data;
                end else begin
                    dp_valid <= 1'b0;
                end
            end
        end
    end

    AST_RD_NOT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (dp_valid && hready && hresp) |=> (!rd_valid && done_err)); // R9
endmodule

// File: rtl/ahbl_burst_master.sv
module ahbl_burst_master
    import ahbl_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int LENW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [2:0]      cmd_burst,
    input  logic [2:0]      cmd_size,
    input  logic            cmd_write,
    input  logic [LENW-1:0] cmd_len,
    input  logic            wr_avail,
    input  logic [DW-1:0]   wr_data,
    output logic            wr_take,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            done,
    output logic            done_err,
    output logic [LENW-1:0] err_beat,
    output logic [AW-1:0]   haddr,
    output logic [1:0]      htrans,
    output logic [2:0]      hburst,
    output logic [2:0]      hsize,
    output logic            hwrite,
    output logic [DW-1:0]   hwdata,
    input  logic [DW-1:0]   hrdata,
    input  logic            hready,
    input  logic            hresp
);
    htrans_t         tr;
    logic            run;
    logic            kill;
    logic            dp_valid;
    logic            start;
    logic [LENW-1:0] ap_beat;
    logic            ap_last;
    logic [DW-1:0]   ap_data;

    assign htrans    = tr;
    assign cmd_ready = !(run || tr[1] || dp_valid);
    assign start     = cmd_valid && cmd_ready;

    ahbl_addr_phase #(.AW(AW), .DW(DW), .LENW(LENW)) u_aph (
        .clk       (clk),
        .rst       (rst),
        .hready    (hready),
        .kill      (kill),
        .start     (start),
        .cmd_addr  (cmd_addr),
        .cmd_burst (cmd_burst),
        .cmd_size  (cmd_size),
        .cmd_write (cmd_write),
        .cmd_len   (cmd_len),
        .wr_avail  (wr_avail),
        .wr_data   (wr_data),
        .haddr     (haddr),
        .htrans    (tr),
        .hburst    (hburst),
        .hsize     (hsize),
        .hwrite    (hwrite),
        .run       (run),
        .wr_take   (wr_take),
        .ap_beat   (ap_beat),
        .ap_last   (ap_last),
        .ap_data   (ap_data)
    );

    ahbl_data_phase #(.DW(DW), .LENW(LENW)) u_dph (
        .clk      (clk),
        .rst      (rst),
        .hready   (hready),
        .hresp    (hresp),
        .hrdata   (hrdata),
        .ap_live  (tr[1]),
        .ap_write (hwrite),
        .ap_beat  (ap_beat),
        .ap_last  (ap_last),
        .ap_data  (ap_data),
        .hwdata   (hwdata),
        .dp_valid (dp_valid),
        .kill     (kill),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .done     (done),
        .done_err (done_err),
        .err_beat (err_beat)
    );

    AST_ERR_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (kill && !hready) |=> (tr == TR_IDLE)); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready); // R10
endmodule

// File: tb/ahbl_burst_master_test.sv
module ahbl_burst_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32, DW = 32, LENW = 8;
    localparam logic [31:0] RKEY  = 32'h5A5A_0000;
    localparam logic [31:0] WBASE = 32'hD000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [2:0] cmd_burst = '0, cmd_size = '0;
    logic [7:0] cmd_len = '0;
    logic wr_avail = 1'b1, wr_take, rd_valid, done, done_err, hwrite;
    logic [31:0] wr_data, rd_data, haddr, hwdata, hrdata;
    logic [7:0] err_beat;
    logic [1:0] htrans;
    logic [2:0] hburst, hsize;
    logic hready = 1'b1, hresp = 1'b0;

    int total = 0, bad = 0, wr_cnt = 0, busy_cnt = 0, ephase = 0, err_at_g = -1, s_idx = 0;
    bit fin = 0, stall_en = 0, gap_en = 0, hold0 = 0, pv = 0;
    logic s_dp = 0, s_wr = 0;
    logic [31:0] s_addr = '0;
    logic [15:0] lfsr = 16'hACE1;
    logic [2:0] cur_b = '0, cur_sz = '0;
    logic cur_w = 0;
    string cur_tag = "R3 addr";
    logic [32:0] exp_q[$];
    logic [31:0] rd_q[$];
    logic [32:0] e;
    logic [31:0] r;
    logic sn_hready = 1, sn_live = 0, sn_nseq = 0, sn_seq = 0, sn_take = 0, sn_hwrite = 0;
    logic [31:0] sn_haddr = '0;
    logic pv_hready = 1, pv_hresp = 0, pv_err1 = 0;
    logic [31:0] pv_haddr = '0;
    logic [1:0] pv_htrans = '0;

    assign hrdata  = s_addr ^ RKEY;
    assign wr_data = WBASE + 32'(wr_cnt);

    ahbl_burst_master #(.AW(AW), .DW(DW), .LENW(LENW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_burst(cmd_burst), .cmd_size(cmd_size),
        .cmd_write(cmd_write), .cmd_len(cmd_len), .wr_avail(wr_avail),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .done_err(done_err), .err_beat(err_beat), .haddr(haddr),
        .htrans(htrans), .hburst(hburst), .hsize(hsize), .hwrite(hwrite),
        .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Slave model and source model: update away from the edge.
    always @(posedge clk) begin
        #1;
        if (rst) begin
            s_dp = 0; s_wr = 0; s_addr = '0; s_idx = 0;
            hready = 1; hresp = 0; wr_avail = 1;
        end else begin
            if (sn_hready) begin
                s_dp = sn_live;
                if (sn_live) begin s_addr = sn_haddr; s_wr = sn_hwrite; end
                if (sn_nseq) s_idx = 0;
                else if (sn_seq) s_idx = s_idx + 1;
            end
            if (sn_take) wr_cnt = wr_cnt + 1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (s_dp && s_idx == err_at_g && ephase == 0) begin
                hready = 0; hresp = 1; ephase = 1;
            end else if (ephase == 1) begin
                hready = 1; hresp = 1; ephase = 2;
            end else begin
                hresp = 0;
                hready = !(stall_en && s_dp && lfsr[1:0] == 2'b00);
            end
            wr_avail = hold0 ? 1'b0 : !(gap_en && lfsr[2] == 1'b0);
        end
    end

    // Monitor / scoreboard.
    always @(negedge clk) begin
        sn_hready = hready; sn_live = htrans[1];
        sn_nseq = (htrans == 2'b10); sn_seq = (htrans == 2'b11);
        sn_take = wr_take; sn_hwrite = hwrite; sn_haddr = haddr;
        if (!rst) begin
            if (hready && htrans[1]) begin
                if (exp_q.size() == 0) chk(0, "R3 extra beat", haddr, 32'h0);
                else begin
                    e = exp_q.pop_front();
                    chk(haddr == e[31:0], cur_tag, haddr, e[31:0]);
                    chk((htrans == 2'b11) == e[32], "R2 beat kind", {30'd0, htrans}, {31'd0, e[32]} + 32'd2);
                    if (htrans == 2'b10)
                        chk({hburst, hsize, hwrite} == {cur_b, cur_sz, cur_w}, "R10 attributes",
                            {25'd0, hburst, hsize, hwrite}, {25'd0, cur_b, cur_sz, cur_w});
                end
            end
            if (htrans == 2'b01) busy_cnt++;
            if (pv && !pv_hready && !pv_hresp)
                chk(haddr == pv_haddr && htrans == pv_htrans, "R5 frozen address phase", haddr, pv_haddr);
            if (pv && pv_err1) chk(htrans == 2'b00, "R9 cancel to IDLE", {30'd0, htrans}, 32'd0);
            if (s_dp && hready && !hresp) begin
                if (s_wr) chk(hwdata == WBASE + 32'(s_idx), "R6 write data", hwdata, WBASE + 32'(s_idx));
                else rd_q.push_back(s_addr ^ RKEY);
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) chk(0, "R7 unexpected rd_valid", rd_data, 32'h0);
                else begin
                    r = rd_q.pop_front();
                    chk(rd_data == r, "R7 read data", rd_data, r);
                end
            end
            pv = 1; pv_hready = hready; pv_hresp = hresp; pv_haddr = haddr; pv_htrans = htrans;
            pv_err1 = s_dp && hresp && !hready;
        end else pv = 0;
    end

    task automatic run_cmd(input logic [31:0] a, input logic [2:0] b, input logic [2:0] sz,
                           input logic w, input int len, input int err_at,
                           input bit stall, input bit gaps, input string tag);
        int n, bytes, blk, cyc;
        bit exp_err;
        logic [31:0] base, ad;
        case (b)
            3'b000: n = 1;
            3'b001: n = len + 1;
            3'b010, 3'b011: n = 4;
            3'b100, 3'b101: n = 8;
            default: n = 16;
        endcase
        bytes = 1 << sz;
        blk = n * bytes;
        for (int i = 0; i < n; i++) begin
            if (err_at >= 0 && i > err_at) break;
            if (b == 3'b010 || b == 3'b100 || b == 3'b110) begin
                base = a - (a % blk);
                ad = base + ((a - base + 32'(i * bytes)) % blk);
            end else ad = a + 32'(i * bytes);
            exp_q.push_back({(i > 0), ad});
        end
        cur_b = b; cur_sz = sz; cur_w = w; cur_tag = tag;
        err_at_g = err_at; stall_en = stall; gap_en = gaps; ephase = 0; wr_cnt = 0; busy_cnt = 0;
        @(negedge clk);
        chk(cmd_ready, "R10 ready before command", {31'd0, cmd_ready}, 32'd1);
        cmd_valid = 1; cmd_addr = a; cmd_burst = b; cmd_size = sz; cmd_write = w; cmd_len = 8'(len);
        @(negedge clk);
        cmd_valid = 0;
        cyc = 0;
        while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
        chk(done, "R10 completion pulse", {31'd0, done}, 32'd1);
        exp_err = (err_at >= 0 && err_at < n);
        chk(done_err == exp_err, "R9 error flag", {31'd0, done_err}, {31'd0, exp_err});
        if (exp_err) chk(err_beat == 8'(err_at), "R9 failing beat index", {24'd0, err_beat}, 32'(err_at));
        chk(cmd_ready, "R10 ready at completion", {31'd0, cmd_ready}, 32'd1);
        @(negedge clk);
        chk(exp_q.size() == 0, "R3 beat count", 32'(exp_q.size()), 32'd0);
        chk(rd_q.size() == 0, "R7 read words returned", 32'(rd_q.size()), 32'd0);
        chk(htrans == 2'b00, "R2 IDLE after burst", {30'd0, htrans}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(htrans == 2'b00, "R1 reset HTRANS", {30'd0, htrans}, 32'd0);
        chk(cmd_ready, "R1 reset cmd_ready", {31'd0, cmd_ready}, 32'd1);
        chk(!done && !rd_valid, "R1 reset pulses", {30'd0, done, rd_valid}, 32'd0);

        run_cmd(32'h100, 3'b000, 3'd2, 1, 0, -1, 0, 0, "R3 SINGLE write");
        run_cmd(32'h200, 3'b011, 3'd2, 0, 0, -1, 0, 0, "R3 INCR4 read");
        run_cmd(32'h030, 3'b001, 3'd1, 1, 5, -1, 0, 0, "R3 INCR len6 write");
        run_cmd(32'h038, 3'b010, 3'd2, 0, 0, -1, 0, 0, "R4 WRAP4 read");
        run_cmd(32'h01C, 3'b100, 3'd2, 1, 0, -1, 0, 0, "R4 WRAP8 write");
        run_cmd(32'h04B, 3'b110, 3'd0, 0, 0, -1, 1, 0, "R4 WRAP16 byte read");
        run_cmd(32'h400, 3'b101, 3'd2, 0, 0, -1, 1, 0, "R5 INCR8 stalled read");
        run_cmd(32'h800, 3'b111, 3'd2, 1, 0, -1, 1, 1, "R8 INCR16 write with gaps");
        chk(busy_cnt > 0, "R8 BUSY inserted", 32'(busy_cnt), 32'd1);
        hold0 = 1;
        run_cmd(32'h900, 3'b011, 3'd2, 0, 0, -1, 0, 0, "R8 read ignores source");
        chk(busy_cnt == 0, "R8 no BUSY on read", 32'(busy_cnt), 32'd0);
        hold0 = 0;
        run_cmd(32'hA00, 3'b101, 3'd2, 1, 0, 3, 0, 0, "R9 INCR8 write with error");
        run_cmd(32'hB00, 3'b001, 3'd2, 0, 3, 0, 1, 0, "R9 error on first beat");
        run_cmd(32'hC00, 3'b000, 3'd2, 0, 0, -1, 0, 0, "R10 SINGLE read after error");

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog R10 act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule